// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers a set of on-chip interrupt sources and four external request lines into one normal interrupt output. Each source carries its own enable, a 3-bit priority and a sensitivity mode. A separate fast interrupt output follows one dedicated external input and nothing else. From the pending, enabled sources the controller picks the one with the highest priority and presents its source number and a vector derived from it.

Service is nested. Software reads the vector register to acknowledge the chosen source. That read pushes the source's priority onto a level stack. While the stack is not empty, only a source with a strictly higher priority than the top entry can raise the normal output again. A write to the end-of-service register pops one level. Internal sources choose between level and rising-edge sensing. External sources can also use low-level and falling-edge sensing.

With the defaults, sources 0 to 3 are internal and sources 4 to 7 are external lines 0 to 3. All registers sit behind a simple synchronous write/read port. Read data arrives one cycle after the read strobe.

Top module: `prio_intc`

## Requirements
- R1: After synchronous reset, irq_out and fiq_out are low, the level stack is empty, and every source configuration reads 0 (disabled, priority 0, high-level mode).
- R2: The configuration of source s is held at address s. Bits [2:0] are the priority, bit 3 is the enable, and bits [5:4] are the mode: 00 high level, 01 rising edge, 10 low level, 11 falling edge. A read returns the stored value in rdata on the cycle after rd_en, with the upper bits zero. Internal sources store bit 5 as 0, so a request for a low-level or falling mode becomes high-level or rising.
- R3: A source whose enable bit is 0 never drives irq_out and never wins selection.
- R4: In a level mode, a source is pending exactly while its line matches the level (high or low). irq_out follows one clock after the pending state changes.
- R5: In an edge mode, a matching edge latches the request. The request stays pending after the line returns and is cleared only when that source is acknowledged. On internal sources, a falling edge raises no request.
- R6: Among eligible sources, the highest priority wins, and ties go to the lowest source number. irq_src shows the winner. A read of address 8 returns 0x0100 + 4 × source number.
- R7: A vector read made while a source is eligible acknowledges that source and pushes its priority. After that, irq_out is raised only by sources whose priority is strictly higher than the top of the stack.
- R8: A vector read made while no source is eligible returns 0xFFFF and leaves the stack unchanged.
- R9: A write to address 9 pops one stack level. On an empty stack it has no effect.
- R10: fiq_out equals fast_in delayed by one clock, is independent of all other sources, and never affects irq_out.
- R11: External line k is source number 4 + k in selection and in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_src | input | 4 | Internal peripheral request lines |
| ext_src | input | 4 | External request lines |
| fast_in | input | 1 | Dedicated external fast request |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 6 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |
| irq_src | output | 3 | Number of the currently selected source |

## Verification
A corrupted stack entry or count shows at the ports in two ways. It shows within two clocks as irq_out staying high or low against the strictly-higher rule. It also shows as a vector read that wrongly returns 0xFFFF or a source number. An edge latch that does not clear on acknowledge keeps irq_out high after the matching end-of-service write. A latch that fails to set leaves irq_out low two clocks after the pulse. Wrong selection shows on irq_src and in the vector value on the cycle after the read. The pairwise sweep covers every ordered pair of sources with distinct and equal priorities.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PW    = 3;
  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'b00,
    SENSE_RISE = 2'b01,
    SENSE_LOW  = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  typedef struct packed {
    sense_e        mode;
    logic          en;
    logic [PW-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/pic_sense.sv
module pic_sense
  import pic_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   line,
  input  sense_e mode,
  input  logic   clr,
  output logic   pend
);
  logic prev_q, latch_q, edge_hit;

  always_comb begin
    case (mode)
      SENSE_RISE: edge_hit = line & ~prev_q;
      SENSE_FALL: edge_hit = EXT ? (~line & prev_q) : 1'b0;
      default:    edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= line;
      if (edge_hit)  latch_q <= 1'b1;
      else if (clr)  latch_q <= 1'b0;
    end
  end

  always_comb begin
    case (mode)
      SENSE_HIGH: pend = line;
      SENSE_LOW:  pend = EXT ? ~line : 1'b0;
      default:    pend = latch_q;
    endcase
  end
endmodule

// File: rtl/pic_select.sv
module pic_select
  import pic_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SW   = 3
) (
  input  logic [NSRC-1:0]         req,
  input  logic [NSRC-1:0][PW-1:0] prio,
  output logic                    any,
  output logic [SW-1:0]           win,
  output logic [PW-1:0]           win_prio
);
  always_comb begin
    any      = 1'b0;
    win      = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!any || prio[i] > win_prio)) begin
        any      = 1'b1;
        win      = SW'(i);
        win_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [PW-1:0] push_val,
  input  logic          pop,
  output logic          empty,
  output logic [PW-1:0] top,
  output logic [CW-1:0] sp
);
  logic [PW-1:0] mem [DEPTH];
  logic [CW-1:0] sp_m1;
  logic          do_push;

  assign do_push = push && (sp != CW'(DEPTH));
  assign sp_m1   = sp - CW'(1);
  assign empty   = (sp == '0);
  assign top     = mem[sp_m1[IW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[sp[IW-1:0]] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)                    sp <= '0;
    else if (do_push)           sp <= sp + CW'(1);
    else if (pop && sp != '0)   sp <= sp_m1;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pic_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_EXT = 4,
  parameter int DW    = 16,
  parameter logic [DW-1:0] VBASE = 16'h0100,
  parameter logic [DW-1:0] SPUR  = 16'hFFFF,
  localparam int NSRC = N_INT + N_EXT,
  localparam int SW   = $clog2(NSRC),
  localparam int AW   = $clog2(NSRC + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_INT-1:0] int_src,
  input  logic [N_EXT-1:0] ext_src,
  input  logic             fast_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [CFG_W-1:0] wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_out,
  output logic             fiq_out,
  output logic [SW-1:0]    irq_src
);
  localparam int ADDR_VEC = NSRC;
  localparam int ADDR_EOI = NSRC + 1;
  localparam int DEPTH    = 1 << PW;
  localparam int CW       = $clog2(DEPTH + 1);

  src_cfg_t                cfg_arr [NSRC];
  logic [NSRC-1:0]         req;
  logic [NSRC-1:0][PW-1:0] prio_v;
  logic                    any, empty, elig, ack, pop;
  logic [SW-1:0]           win;
  logic [PW-1:0]           win_prio, top;
  logic [CW-1:0]           lvl_cnt;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam bit IS_EXT = (g >= N_INT);
    localparam logic [CFG_W-1:0] WMASK = IS_EXT ? 6'h3F : 6'h1F;
    logic     line, pend;
    src_cfg_t cfg_q;

    if (g < N_INT) begin : g_i
      assign line = int_src[g];
    end else begin : g_e
      assign line = ext_src[g-N_INT];
    end

    always_ff @(posedge clk) begin
      if (rst)                             cfg_q <= '0;
      else if (wr_en && addr == AW'(g))    cfg_q <= src_cfg_t'(wdata & WMASK);
    end

    pic_sense #(.EXT(IS_EXT)) u_sense (
      .clk  (clk),
      .rst  (rst),
      .line (line),
      .mode (cfg_q.mode),
      .clr  (ack && (win == SW'(g))),
      .pend (pend)
    );

    assign req[g]     = pend & cfg_q.en;
    assign prio_v[g]  = cfg_q.prio;
    assign cfg_arr[g] = cfg_q;
  end

  pic_select #(.NSRC(NSRC), .SW(SW)) u_sel (
    .req      (req),
    .prio     (prio_v),
    .any      (any),
    .win      (win),
    .win_prio (win_prio)
  );

  assign elig = any && (empty || win_prio > top);
  assign ack  = rd_en && (addr == AW'(ADDR_VEC)) && elig;
  assign pop  = wr_en && (addr == AW'(ADDR_EOI));

  pic_stack #(.DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk      (clk),
    .rst      (rst),
    .push     (ack),
    .push_val (win_prio),
    .pop      (pop),
    .empty    (empty),
    .top      (top),
    .sp       (lvl_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
      irq_src <= '0;
    end else begin
      irq_out <= elig;
      fiq_out <= fast_in;
      irq_src <= win;
      if (rd_en) begin
        if (addr < AW'(NSRC))
          rdata <= {{(DW-CFG_W){1'b0}}, cfg_arr[addr[SW-1:0]]};
        else if (addr == AW'(ADDR_VEC))
          rdata <= elig ? (VBASE + (DW'(win) << 2)) : SPUR;
        else
          rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          fast_in,
  input logic          fiq_out,
  input logic          irq_out,
  input logic          ack,
  input logic          pop,
  input logic [CW-1:0] sp
);
  // R10
  fiq_follow_chk: assert property (@(posedge clk) disable iff (rst) fast_in |=> fiq_out);
  // R10
  fiq_quiet_chk: assert property (@(posedge clk) disable iff (rst) !fast_in |=> !fiq_out);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq_out && !fiq_out && sp == '0));
  // R7
  ack_push_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> sp == $past(sp) + CW'(1));
  // R9
  eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !ack && sp == '0) |=> sp == '0);
  // R9
  eoi_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !ack && sp != '0) |=> sp == $past(sp) - CW'(1));
  // R7
  stack_bound_chk: assert property (@(posedge clk) disable iff (rst) sp <= CW'(DEPTH));
endmodule

bind prio_intc pic_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .fast_in (fast_in),
  .fiq_out (fiq_out),
  .irq_out (irq_out),
  .ack     (ack),
  .pop     (pop),
  .sp      (lvl_cnt)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int VEC = 8;
  localparam int EOI = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  int_src = '0;
  logic [3:0]  ext_src = '0;
  logic        fast_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [5:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq_out, fiq_out;
  logic [2:0]  irq_src;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rst(rst), .int_src(int_src), .ext_src(ext_src), .fast_in(fast_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_out(irq_out), .fiq_out(fiq_out), .irq_src(irq_src)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = 6'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; v = int'(rdata);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_src(input int s, input bit v);
    if (s < 4) int_src[s] = v; else ext_src[s-4] = v;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_eq("R1 irq", irq_out, 0);
    chk_eq("R1 fiq", fiq_out, 0);
    for (int s = 0; s < 8; s++) begin
      rd(s, v); chk_eq("R1 cfg", v, 0);
    end
    // R8 spurious right after reset
    rd(VEC, v); chk_eq("R8 spurious", v, 16'hFFFF);

    // R2 readback, internal bit5 cleared
    for (int s = 0; s < 8; s++) begin
      wr(s, 6'h37);
      rd(s, v); chk_eq("R2 readback", v, (s < 4) ? 6'h17 : 6'h37);
      wr(s, 0);
    end

    // R6/R7/R11 pairwise sweep, level-high sources
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        if (a != b) begin
          int pa, pb, w;
          pa = (a * 3) % 8;
          pb = (b * 5 + 1) % 8;
          w  = (pa > pb) ? a : (pb > pa) ? b : ((a < b) ? a : b);
          wr(a, 8 | pa); wr(b, 8 | pb);
          set_src(a, 1'b1); set_src(b, 1'b1);
          settle();
          chk_eq("R6 irq", irq_out, 1);
          chk_eq("R6 src", irq_src, w);
          rd(VEC, v); chk_eq("R6 vector", v, 16'h0100 + 4 * w);
          settle();
          chk_eq("R7 masked by level", irq_out, 0);
          wr(EOI, 0);
          set_src(a, 1'b0); set_src(b, 1'b0);
          wr(a, 0); wr(b, 0);
          settle();
        end
      end
    end

    // R4 level high drops with the line
    wr(3, 8 | 7); int_src[3] = 1'b1; settle();
    chk_eq("R4 high pending", irq_out, 1);
    int_src[3] = 1'b0; settle();
    chk_eq("R4 high released", irq_out, 0);
    wr(3, 0);

    // R4 low level on external line 2 (source 6)
    wr(6, 6'h2E); settle();
    chk_eq("R4 low pending", irq_out, 1);
    rd(VEC, v); chk_eq("R11 low vector", v, 16'h0118);
    wr(EOI, 0);
    ext_src[2] = 1'b1; settle();
    chk_eq("R4 low released", irq_out, 0);
    wr(6, 0); ext_src[2] = 1'b0;

    // R5 rising edge, external line 0 (source 4)
    wr(4, 6'h1B);
    @(negedge clk); ext_src[0] = 1'b1;
    @(negedge clk); ext_src[0] = 1'b0;
    settle();
    chk_eq("R5 rise latched", irq_out, 1);
    rd(VEC, v); chk_eq("R5 rise vector", v, 16'h0110);
    wr(EOI, 0); settle();
    chk_eq("R5 rise cleared", irq_out, 0);
    wr(4, 0);

    // R5 falling edge, external line 1 (source 5)
    ext_src[1] = 1'b1; settle();
    wr(5, 6'h3A); settle();
    chk_eq("R5 fall idle", irq_out, 0);
    ext_src[1] = 1'b0; settle();
    chk_eq("R5 fall latched", irq_out, 1);
    rd(VEC, v); chk_eq("R5 fall vector", v, 16'h0114);
    wr(EOI, 0); settle();
    chk_eq("R5 fall cleared", irq_out, 0);
    wr(5, 0);

    // R5 internal rising (source 1)
    wr(1, 6'h19);
    @(negedge clk); int_src[1] = 1'b1;
    @(negedge clk); int_src[1] = 1'b0;
    settle();
    chk_eq("R5 int rise", irq_out, 1);
    rd(VEC, v); chk_eq("R5 int vector", v, 16'h0104);
    wr(EOI, 0); settle();
    chk_eq("R5 int cleared", irq_out, 0);
    wr(1, 0);

    // R2/R5 internal source asked for falling mode acts as rising
    int_src[2] = 1'b1; settle();
    wr(2, 6'h3C);
    rd(2, v); chk_eq("R2 internal mode", v, 6'h1C);
    settle();
    chk_eq("R5 no edge yet", irq_out, 0);
    int_src[2] = 1'b0; settle();
    chk_eq("R5 internal fall ignored", irq_out, 0);
    int_src[2] = 1'b1; settle();
    chk_eq("R5 internal rise", irq_out, 1);
    rd(VEC, v); chk_eq("R5 internal vector", v, 16'h0108);
    wr(EOI, 0); wr(2, 0); int_src[2] = 1'b0; settle();

    // R3 mask, R8 spurious without push
    ext_src[3] = 1'b1; wr(7, 6'h07); settle();
    chk_eq("R3 masked", irq_out, 0);
    rd(VEC, v); chk_eq("R8 masked spurious", v, 16'hFFFF);
    wr(7, 6'h08); settle();
    chk_eq("R8 stack untouched", irq_out, 1);
    chk_eq("R11 src", irq_src, 7);
    wr(7, 0); ext_src[3] = 1'b0; settle();

    // R7 nesting
    wr(0, 6'h0A); wr(3, 6'h0A); wr(2, 6'h0D);
    int_src[0] = 1'b1; settle();
    rd(VEC, v); chk_eq("R7 first vector", v, 16'h0100);
    settle(); chk_eq("R7 held off", irq_out, 0);
    int_src[3] = 1'b1; settle();
    chk_eq("R7 equal held off", irq_out, 0);
    int_src[2] = 1'b1; settle();
    chk_eq("R7 preempt", irq_out, 1);
    chk_eq("R7 preempt src", irq_src, 2);
    rd(VEC, v); chk_eq("R7 nested vector", v, 16'h0108);
    settle(); chk_eq("R7 nested held", irq_out, 0);
    wr(EOI, 0); settle();
    chk_eq("R9 pop reopens", irq_out, 1);
    int_src[2] = 1'b0; settle();
    chk_eq("R7 back at level", irq_out, 0);
    wr(EOI, 0); settle();
    chk_eq("R9 empty again", irq_out, 1);
    chk_eq("R6 tie lowest", irq_src, 0);
    rd(VEC, v); chk_eq("R6 tie vector", v, 16'h0100);
    wr(EOI, 0);
    int_src[0] = 1'b0; int_src[3] = 1'b0;
    wr(0, 0); wr(3, 0); wr(2, 0); settle();

    // R9 pop on empty has no effect
    wr(EOI, 0); wr(EOI, 0); wr(EOI, 0);
    wr(1, 6'h08); int_src[1] = 1'b1; settle();
    chk_eq("R9 empty pop harmless", irq_out, 1);
    rd(VEC, v); chk_eq("R9 vector", v, 16'h0104);
    settle(); chk_eq("R9 pushed", irq_out, 0);
    wr(EOI, 0); settle();
    chk_eq("R9 popped", irq_out, 1);
    int_src[1] = 1'b0; wr(1, 0); settle();

    // R10 fast path
    fast_in = 1'b1;
    @(negedge clk);
    chk_eq("R10 fiq high", fiq_out, 1);
    chk_eq("R10 irq unaffected", irq_out, 0);
    fast_in = 1'b0;
    @(negedge clk);
    chk_eq("R10 fiq low", fiq_out, 0);
    wr(4, 6'h09); ext_src[0] = 1'b1; settle();
    chk_eq("R10 irq alone", irq_out, 1);
    chk_eq("R10 fiq stays low", fiq_out, 0);
    rd(VEC, v); chk_eq("R11 ext vector", v, 16'h0110);
    wr(EOI, 0); wr(4, 0); ext_src[0] = 1'b0; settle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule